// File: doc/BRIEF.md
# Dual-Form Maximal-Length LFSR Generator

This block is a 16-bit pseudo-random bit source built on a maximal-length linear-feedback shift register with the feedback polynomial x^16 + x^14 + x^13 + x^11 + 1. Two elaboration-time parameters choose its structure and polarity. The structure is either the external-XOR form, where one combined feedback bit enters the input end, or the internal-XOR form, where the output bit is folded into the tapped stages as the register shifts. The polarity is either XOR or XNOR feedback. Each enabled clock advances the register by one state. The block offers the serial output bit and the whole parallel state.

A seed can be loaded at any time. A seed load takes priority over everything else. Each polarity has one illegal state, from which the register can never leave on its own: all zeros for XOR and all ones for XNOR. When the register holds that state, the block replaces it with a fixed legal escape value on the next clock and raises a one-cycle flag. Stream users can therefore recover from a bad seed without any outside supervision.

Top module: `lfsr_dual_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `RESET_SEED` (default 0xACE1) and `lockup_recovered` becomes 0.
- R2: When `seed_load` is high at a rising edge, `state_out` takes `seed_value` after that edge. This happens even if `step_en` is high or the state is illegal.
- R3: When `seed_load` and `step_en` are both low and the state is legal, the state holds its value.
- R4: External-XOR form. Tap position p (1 to 16, where position 1 is the input end) is `state_out[p-1]`. An enabled step moves bit i to bit i+1. The new bit 0 is the XOR of bits 15, 13, 12 and 10, inverted when XNOR is selected. Example: 0x8000 steps to 0x0001.
- R5: Internal-XOR form. Let out be bit 15. An enabled step sets bit 0 to out. Bits 2, 3 and 5 take bit j-1 XOR out (XNOR with XNOR polarity). Every other bit j takes bit j-1. Examples: 0x8000 steps to 0x002D and 0x0001 steps to 0x0002.
- R6: `serial_out` always equals bit 15 of `state_out`.
- R7: Starting from a legal state and stepping continuously, the register returns to its start state after exactly 65535 steps and never reaches the illegal state.
- R8: The illegal state is 0x0000 for XOR and 0xFFFF for XNOR. If it is held at a rising edge without `seed_load`, the state becomes the escape value (0x0001 for XOR, 0xFFFE for XNOR) whatever `step_en` is, and `lockup_recovered` is 1 after that edge.
- R9: `lockup_recovered` is high for exactly one cycle for each recovery, and is never high otherwise.
- R10: For the same polarity, the serial stream of the internal-XOR form equals the stream of the external-XOR form shifted in time. An external-XOR register seeded with bit (15-k) set to the k-th internal-XOR output bit, for k = 0..15, reproduces that stream bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the register by one state this cycle |
| seed_load | input | 1 | Load `seed_value` into the register |
| seed_value | input | 16 | Seed to load |
| serial_out | output | 1 | Output-end bit of the register |
| state_out | output | 16 | Full register state |
| lockup_recovered | output | 1 | One-cycle pulse after an illegal state was replaced |

## Verification
The bench builds four copies of the block, one for each pair of structure and polarity, all with the default width, tap mask and reset seed. With all four present, both illegal states and both escape values can be reached, and the single-step results of each form can be checked against hand-computed values. Each internal-XOR stream can be compared against its external-XOR partner of the same polarity. A full 65535-step period runs on all four copies side by side.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic {
        ARCH_FIB = 1'b0,
        ARCH_GAL = 1'b1
    } arch_e;

    typedef enum logic {
        POL_XOR  = 1'b0,
        POL_XNOR = 1'b1
    } pol_e;

endpackage

// File: rtl/lfsr_step_logic.sv
module lfsr_step_logic #(
    parameter int                  WIDTH = 16,
    parameter logic [WIDTH-1:0]    TAPS  = 16'hB400,
    parameter lfsr_pkg::arch_e     ARCH  = lfsr_pkg::ARCH_FIB,
    parameter lfsr_pkg::pol_e      POL   = lfsr_pkg::POL_XOR
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    localparam logic INV = (POL == lfsr_pkg::POL_XNOR);

    if (ARCH == lfsr_pkg::ARCH_FIB) begin : g_fib
        // Single wide parity of the tapped bits enters the input end.
        logic fb;
        assign fb  = (^(cur & TAPS)) ^ INV;
        assign nxt = {cur[WIDTH-2:0], fb};
    end else begin : g_gal
        // Output bit is folded into the mirrored tap stages as the register shifts.
        logic out_bit;
        assign out_bit = cur[WIDTH-1];
        assign nxt[0]  = out_bit;
        for (genvar j = 1; j < WIDTH; j++) begin : g_bit
            if (TAPS[WIDTH-1-j]) begin : g_tap
                assign nxt[j] = cur[j-1] ^ out_bit ^ INV;
            end else begin : g_pass
                assign nxt[j] = cur[j-1];
            end
        end
    end

endmodule

// File: rtl/lfsr_lock_detect.sv
module lfsr_lock_detect #(
    parameter int             WIDTH = 16,
    parameter lfsr_pkg::pol_e POL   = lfsr_pkg::POL_XOR
) (
    input  logic [WIDTH-1:0] cur,
    output logic             is_locked
);
    localparam logic [WIDTH-1:0] LOCK_STATE =
        (POL == lfsr_pkg::POL_XNOR) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

    assign is_locked = (cur == LOCK_STATE);

endmodule

// File: rtl/lfsr_dual_gen.sv
module lfsr_dual_gen #(
    parameter int               WIDTH      = 16,
    parameter logic [WIDTH-1:0] TAPS       = 16'hB400,
    parameter lfsr_pkg::arch_e  ARCH       = lfsr_pkg::ARCH_FIB,
    parameter lfsr_pkg::pol_e   POL        = lfsr_pkg::POL_XOR,
    parameter logic [WIDTH-1:0] RESET_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_value,
    output logic             serial_out,
    output logic [WIDTH-1:0] state_out,
    output logic             lockup_recovered
);
    localparam logic [WIDTH-1:0] LOCK_STATE =
        (POL == lfsr_pkg::POL_XNOR) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] ESCAPE_STATE =
        LOCK_STATE ^ {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] state;
        logic             recovered;
    } regs_t;

    regs_t            r_d, r_q;
    logic [WIDTH-1:0] step_nxt;
    logic             locked;

    lfsr_step_logic #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS),
        .ARCH  (ARCH),
        .POL   (POL)
    ) u_step (
        .cur (r_q.state),
        .nxt (step_nxt)
    );

    lfsr_lock_detect #(
        .WIDTH (WIDTH),
        .POL   (POL)
    ) u_lock (
        .cur       (r_q.state),
        .is_locked (locked)
    );

    always_comb begin
        r_d           = r_q;
        r_d.recovered = 1'b0;
        if (seed_load) begin
            r_d.state = seed_value;
        end else if (locked) begin
            r_d.state     = ESCAPE_STATE;
            r_d.recovered = 1'b1;
        end else if (step_en) begin
            r_d.state = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state     <= RESET_SEED;
            r_q.recovered <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_out        = r_q.state;
    assign serial_out       = r_q.state[WIDTH-1];
    assign lockup_recovered = r_q.recovered;

endmodule

// File: rtl/lfsr_dual_gen_chk.sv
module lfsr_dual_gen_chk #(
    parameter int               WIDTH      = 16,
    parameter lfsr_pkg::arch_e  ARCH       = lfsr_pkg::ARCH_FIB,
    parameter lfsr_pkg::pol_e   POL        = lfsr_pkg::POL_XOR,
    parameter logic [WIDTH-1:0] RESET_SEED = 16'hACE1
) (
    input logic             clk,
    input logic             rst,
    input logic             step_en,
    input logic             seed_load,
    input logic [WIDTH-1:0] seed_value,
    input logic             serial_out,
    input logic [WIDTH-1:0] state_out,
    input logic             lockup_recovered
);
    localparam logic [WIDTH-1:0] LOCK_STATE =
        (POL == lfsr_pkg::POL_XNOR) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] ESCAPE_STATE =
        LOCK_STATE ^ {{(WIDTH-1){1'b0}}, 1'b1};

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (state_out == RESET_SEED) && !lockup_recovered);

    a_r2_seed_load: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> state_out == $past(seed_value));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !step_en && state_out != LOCK_STATE) |=> $stable(state_out));

    if (ARCH == lfsr_pkg::ARCH_FIB) begin : g_fib_chk
        a_r4_fib_shift: assert property (@(posedge clk) disable iff (rst)
            (step_en && !seed_load && state_out != LOCK_STATE)
            |=> state_out[WIDTH-1:1] == $past(state_out[WIDTH-2:0]));
    end else begin : g_gal_chk
        a_r5_gal_input: assert property (@(posedge clk) disable iff (rst)
            (step_en && !seed_load && state_out != LOCK_STATE)
            |=> state_out[0] == $past(serial_out));
    end

    a_r7_no_lock: assert property (@(posedge clk) disable iff (rst)
        (step_en && !seed_load && state_out != LOCK_STATE) |=> state_out != LOCK_STATE);

    a_r8_escape: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && state_out == LOCK_STATE)
        |=> (state_out == ESCAPE_STATE) && lockup_recovered);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        lockup_recovered |=> !lockup_recovered);

    a_r9_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(lockup_recovered) |-> $past(state_out == LOCK_STATE && !seed_load));

endmodule

bind lfsr_dual_gen lfsr_dual_gen_chk #(
    .WIDTH      (WIDTH),
    .ARCH       (ARCH),
    .POL        (POL),
    .RESET_SEED (RESET_SEED)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .step_en          (step_en),
    .seed_load        (seed_load),
    .seed_value       (seed_value),
    .serial_out       (serial_out),
    .state_out        (state_out),
    .lockup_recovered (lockup_recovered)
);

// File: tb/lfsr_dual_gen_tb.sv
module lfsr_dual_gen_tb;
    localparam time CLK_PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld [4];
    logic        en [4];
    logic [15:0] sd [4];
    logic [15:0] st [4];
    logic        so [4];
    logic        fl [4];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // 0: external XOR, 1: internal XOR, 2: external XNOR, 3: internal XNOR
    lfsr_dual_gen #(.ARCH(lfsr_pkg::ARCH_FIB), .POL(lfsr_pkg::POL_XOR)) u_dut (
        .clk(clk), .rst(rst), .step_en(en[0]), .seed_load(ld[0]), .seed_value(sd[0]),
        .serial_out(so[0]), .state_out(st[0]), .lockup_recovered(fl[0]));
    lfsr_dual_gen #(.ARCH(lfsr_pkg::ARCH_GAL), .POL(lfsr_pkg::POL_XOR)) u_dut_gx (
        .clk(clk), .rst(rst), .step_en(en[1]), .seed_load(ld[1]), .seed_value(sd[1]),
        .serial_out(so[1]), .state_out(st[1]), .lockup_recovered(fl[1]));
    lfsr_dual_gen #(.ARCH(lfsr_pkg::ARCH_FIB), .POL(lfsr_pkg::POL_XNOR)) u_dut_fn (
        .clk(clk), .rst(rst), .step_en(en[2]), .seed_load(ld[2]), .seed_value(sd[2]),
        .serial_out(so[2]), .state_out(st[2]), .lockup_recovered(fl[2]));
    lfsr_dual_gen #(.ARCH(lfsr_pkg::ARCH_GAL), .POL(lfsr_pkg::POL_XNOR)) u_dut_gn (
        .clk(clk), .rst(rst), .step_en(en[3]), .seed_load(ld[3]), .seed_value(sd[3]),
        .serial_out(so[3]), .state_out(st[3]), .lockup_recovered(fl[3]));

    function automatic logic [15:0] lock_of(input int i);
        return (i < 2) ? 16'h0000 : 16'hFFFF;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_all();
        for (int i = 0; i < 4; i++) begin
            ld[i] = 1'b0; en[i] = 1'b0; sd[i] = 16'h0000;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        for (int i = 0; i < 4; i++) begin
            chk(st[i] == 16'hACE1, "R1", "reset state", st[i], 16'hACE1);
            chk(fl[i] == 1'b0, "R1", "reset flag", fl[i], 0);
        end
        rst = 1'b0;
    endtask

    task automatic t_single_step(input logic [15:0] s0, s1, s2, s3,
                                 input logic [15:0] e0, e1, e2, e3);
        logic [15:0] seeds [4];
        logic [15:0] exps  [4];
        seeds[0] = s0; seeds[1] = s1; seeds[2] = s2; seeds[3] = s3;
        exps[0]  = e0; exps[1]  = e1; exps[2]  = e2; exps[3]  = e3;
        for (int i = 0; i < 4; i++) begin
            ld[i] = 1'b1; en[i] = 1'b1; sd[i] = seeds[i];  // load wins over step
        end
        tick();
        for (int i = 0; i < 4; i++) begin
            chk(st[i] == seeds[i], "R2", "load with step_en high", st[i], seeds[i]);
            chk(so[i] == seeds[i][15], "R6", "serial after load", so[i], seeds[i][15]);
            ld[i] = 1'b0;
        end
        tick();
        for (int i = 0; i < 4; i++) begin
            chk(st[i] == exps[i], (i % 2 == 0) ? "R4" : "R5", "one step", st[i], exps[i]);
            chk(so[i] == exps[i][15], "R6", "serial after step", so[i], exps[i][15]);
            en[i] = 1'b0;
        end
    endtask

    task automatic t_hold();
        logic [15:0] snap [4];
        for (int i = 0; i < 4; i++) begin
            en[i] = 1'b0; ld[i] = 1'b0; sd[i] = 16'h1234;
            snap[i] = st[i];
        end
        tick(); tick(); tick();
        for (int i = 0; i < 4; i++)
            chk(st[i] == snap[i], "R3", "hold with step_en low", st[i], snap[i]);
    endtask

    task automatic t_lockup(input logic step);
        for (int i = 0; i < 4; i++) begin
            ld[i] = 1'b1; en[i] = step; sd[i] = lock_of(i);
        end
        tick();
        for (int i = 0; i < 4; i++) begin
            chk(st[i] == lock_of(i), "R2", "illegal seed loaded", st[i], lock_of(i));
            chk(fl[i] == 1'b0, "R9", "no flag while loading", fl[i], 0);
            ld[i] = 1'b0;
        end
        tick();
        for (int i = 0; i < 4; i++) begin
            chk(st[i] == (lock_of(i) ^ 16'h0001), "R8", "escape value", st[i],
                lock_of(i) ^ 16'h0001);
            chk(fl[i] == 1'b1, "R8", "flag after escape", fl[i], 1);
            en[i] = 1'b0;
        end
        tick();
        for (int i = 0; i < 4; i++) begin
            chk(fl[i] == 1'b0, "R9", "flag lasts one cycle", fl[i], 0);
            chk(st[i] == (lock_of(i) ^ 16'h0001), "R3", "escape value held", st[i],
                lock_of(i) ^ 16'h0001);
        end
    endtask

    task automatic t_equiv(input int g, input int f);
        logic bits [0:255];
        logic [15:0] fseed;
        int mism;
        int rec_bad;
        logic inv;
        inv = (g >= 2);
        ld[g] = 1'b1; en[g] = 1'b0; sd[g] = 16'hACE1;
        tick();
        ld[g] = 1'b0; en[g] = 1'b1;
        for (int k = 0; k < 216; k++) begin
            bits[k] = so[g];
            tick();
        end
        en[g] = 1'b0;
        rec_bad = 0;
        for (int t = 0; t < 200; t++)
            if (bits[t+16] != (bits[t] ^ bits[t+2] ^ bits[t+3] ^ bits[t+5] ^ inv))
                rec_bad++;
        chk(rec_bad == 0, "R10", "internal form obeys polynomial recurrence", rec_bad, 0);
        fseed = 16'h0000;
        for (int k = 0; k < 16; k++) fseed[15-k] = bits[k];
        ld[f] = 1'b1; en[f] = 1'b0; sd[f] = fseed;
        tick();
        ld[f] = 1'b0; en[f] = 1'b1;
        mism = 0;
        for (int k = 0; k < 216; k++) begin
            if (so[f] != bits[k]) mism++;
            tick();
        end
        en[f] = 1'b0;
        chk(mism == 0, "R10", "streams equal after time shift", mism, 0);
    endtask

    task automatic t_period();
        int  cnt  [4];
        bit  done [4];
        int  seen_lock [4];
        int  seen_flag [4];
        for (int i = 0; i < 4; i++) begin
            ld[i] = 1'b1; en[i] = 1'b0; sd[i] = 16'hACE1;
            cnt[i] = 0; done[i] = 1'b0; seen_lock[i] = 0; seen_flag[i] = 0;
        end
        tick();
        for (int i = 0; i < 4; i++) begin
            ld[i] = 1'b0; en[i] = 1'b1;
        end
        for (int n = 0; n < 65600; n++) begin
            tick();
            for (int i = 0; i < 4; i++) begin
                if (!done[i]) begin
                    cnt[i]++;
                    if (st[i] == lock_of(i)) seen_lock[i]++;
                    if (fl[i]) seen_flag[i]++;
                    if (st[i] == 16'hACE1) done[i] = 1'b1;
                end
            end
            if (done[0] && done[1] && done[2] && done[3]) break;
        end
        for (int i = 0; i < 4; i++) begin
            en[i] = 1'b0;
            chk(cnt[i] == 65535, "R7", "period length", cnt[i], 65535);
            chk(seen_lock[i] == 0, "R7", "illegal state reached", seen_lock[i], 0);
            chk(seen_flag[i] == 0, "R9", "flag during normal run", seen_flag[i], 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_all();
        t_reset();
        // R4/R5: tap bits all set in the output end
        t_single_step(16'h8000, 16'h8000, 16'h7FFF, 16'h7FFF,
                      16'h0001, 16'h002D, 16'hFFFE, 16'hFFD2);
        // R4/R5: one lone tap bit, and a plain shift with output bit clear
        t_single_step(16'h0400, 16'h0001, 16'hFBFF, 16'hFFFE,
                      16'h0801, 16'h0002, 16'hF7FE, 16'hFFFD);
        t_hold();
        t_lockup(1'b0);
        t_lockup(1'b1);
        t_equiv(1, 0);
        t_equiv(3, 2);
        t_period();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule